// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. Holding the active-low load input low copies the parallel data word into a chain of stages. Once load is released, the chain moves one stage toward the last stage on each qualifying edge of a gated shift clock. On each such shift, the first stage takes a new bit from the serial input. Only the last stage can be seen from outside, as a true output and a complement output.

The shift clock is formed from two interchangeable inputs that are combined by OR. Either input held high blocks the other, and either input held low lets the other act as the clock. The block runs in one fast system-clock domain. Every external input, including the parallel word, passes through a synchronizer chain of configurable depth. The rising edges of the OR-combined clock are then detected in that domain. A system-clock reset clears the stages, the synchronizers and the edge history.

Top module: `piso_shreg`

## Requirements
- R1: While `rst_n` is low at a system clock edge, every stage clears to 0, so `q_last` reads 0 and `q_last_n` reads 1.
- R2: While `ld_n` is low, the stages follow `par_in`: bit i of `par_in` goes to stage i, and stage WIDTH-1 drives `q_last`. This holds whatever `clk_a`, `clk_b` and `ser_in` do.
- R3: While `ld_n` is high, changes on `par_in` have no effect on the stored word.
- R4: A rising edge of (`clk_a` OR `clk_b`) with `ld_n` high shifts the word by one stage. `ser_in` enters stage 0, and stage i takes the old stage i-1.
- R5: Either clock input held high suppresses edges on the other input. The two inputs behave identically.
- R6: Without a qualifying edge the word holds. Releasing `ld_n` does not cause a shift by itself.
- R7: `q_last_n` is always the complement of `q_last`.
- R8: After a load of word d, successive shifts present d[WIDTH-1], d[WIDTH-2], … d[0] on `q_last`, followed by the serial bits in the order they were shifted in.
- R9: A change of any input takes effect on the outputs at the (SYNC_STAGES+1)-th rising system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Level load control, low copies `par_in` |
| clk_a | input | 1 | Shift clock input, interchangeable with `clk_b` |
| clk_b | input | 1 | Shift clock input, used as the inhibit |
| ser_in | input | 1 | Serial bit entering stage 0 |
| par_in | input | WIDTH | Parallel word, bit i goes to stage i |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The bench builds the block with WIDTH=12 and SYNC_STAGES=3. At that width, the serial tail after a load is longer than a byte, so the ordering of R8 is checked over a non-default width. The three-flop synchronizer moves the load and edge response to the fourth system clock edge. This lets the R9 latency check tell the configured depth apart from the default one. Randomly mixed loads, shifts on either clock input, parallel-input changes and idle periods exercise the interaction of load, inhibit and hold.

// File: rtl/piso_pkg.sv
package piso_pkg;
   // action taken by the stage chain in one system clock cycle
   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_LOAD  = 2'd1,
      STEP_SHIFT = 2'd2
   } step_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("piso_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[i]};
         end
         assign q[i] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_a_s,
   input  logic clk_b_s,
   output logic rise
);
   logic comb_clk;
   logic comb_prev;

   assign comb_clk = clk_a_s | clk_b_s;

   always_ff @(posedge clk) begin
      if (!rst_n) comb_prev <= 1'b0;
      else        comb_prev <= comb_clk;
   end

   assign rise = comb_clk & ~comb_prev;

   // R5
   inhibit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_a_s && $past(clk_a_s)) |-> !rise);
   // R5
   inhibit_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_b_s && $past(clk_b_s)) |-> !rise);
   // R4
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/piso_stages.sv
module piso_stages
   import piso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_n_s,
   input  logic             rise,
   input  logic             ser_s,
   input  logic [WIDTH-1:0] par_s,
   output logic [WIDTH-1:0] stage
);
   step_e step;

   always_comb begin
      if (!ld_n_s)   step = STEP_LOAD;
      else if (rise) step = STEP_SHIFT;
      else           step = STEP_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage <= '0;
      end else begin
         case (step)
            STEP_LOAD:  stage <= par_s;
            STEP_SHIFT: stage <= {stage[WIDTH-2:0], ser_s};
            default:    stage <= stage;
         endcase
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (stage == '0));
   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_n_s |=> (stage == $past(par_s)));
   // R4
   shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_n_s && rise) |=> (stage == {$past(stage[WIDTH-2:0]), $past(ser_s)}));
   // R6
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_n_s && !rise) |=> $stable(stage));
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_n,
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             q_last,
   output logic             q_last_n
);
   localparam int BUS_W = WIDTH + 4;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("piso_shreg: WIDTH must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0] raw_bus;
   logic [BUS_W-1:0] sync_bus;
   logic             ld_n_s, ser_s, clk_a_s, clk_b_s, rise;
   logic [WIDTH-1:0] par_s;
   logic [WIDTH-1:0] stage;

   assign raw_bus = {ld_n, ser_in, clk_a, clk_b, par_in};

   piso_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (sync_bus)
   );

   assign {ld_n_s, ser_s, clk_a_s, clk_b_s, par_s} = sync_bus;

   piso_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_a_s (clk_a_s),
      .clk_b_s (clk_b_s),
      .rise    (rise)
   );

   piso_stages #(.WIDTH(WIDTH)) u_stages (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_n_s (ld_n_s),
      .rise   (rise),
      .ser_s  (ser_s),
      .par_s  (par_s),
      .stage  (stage)
   );

   assign q_last   = stage[WIDTH-1];
   assign q_last_n = ~stage[WIDTH-1];
endmodule

// File: tb/piso_shreg_test.sv
`timescale 1ns/1ps
module piso_shreg_test;
   localparam int W      = 12;
   localparam int SS     = 3;
   localparam int SETTLE = SS + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_n = 1'b1;
   logic         clk_a = 1'b0;
   logic         clk_b = 1'b0;
   logic         ser_in = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         q_last, q_last_n;

   int           n_tests = 0;
   int           n_fail = 0;
   bit           finished = 1'b0;
   logic [W-1:0] model = '0;

   always #2 clk = ~clk;

   piso_shreg #(.WIDTH(W), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .clk_a(clk_a), .clk_b(clk_b),
      .ser_in(ser_in), .par_in(par_in), .q_last(q_last), .q_last_n(q_last_n)
   );

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] shift_in(input logic [W-1:0] v, input logic s);
      return {v[W-2:0], s};
   endfunction

   task automatic check_out(input string req);
      chk(req, q_last, model[W-1]);
      chk("R7", q_last_n, ~model[W-1]);
   endtask

   // load with optional clock and serial activity during the load (R2)
   task automatic do_load(input logic [W-1:0] d, input bit noisy);
      par_in = d;
      ld_n = 1'b0;
      idle(SETTLE);
      if (noisy) begin
         ser_in = ~ser_in; clk_a = 1'b1; idle(SETTLE);
         clk_a = 1'b0; clk_b = 1'b1; idle(SETTLE);
         clk_b = 1'b0; idle(SETTLE);
      end
      model = d;
      chk("R2", q_last, d[W-1]);
      ld_n = 1'b1;
      idle(SETTLE);
      check_out("R6");
   endtask

   task automatic pulse(input bit use_b, input logic s);
      ser_in = s;
      idle(SETTLE);
      if (use_b) clk_b = 1'b1; else clk_a = 1'b1;
      idle(SETTLE);
      clk_a = 1'b0; clk_b = 1'b0;
      idle(SETTLE);
      model = shift_in(model, s);
      check_out("R4");
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] d;
      logic [W-1:0] sbits;
      void'($urandom(32'd4021));
      idle(5);
      // R1
      chk("R1", q_last, 1'b0);
      chk("R1", q_last_n, 1'b1);
      rst_n = 1'b1;
      idle(SETTLE);
      chk("R1", q_last, 1'b0);

      // R9 latency: load ones over zeros, output flips at edge SS+1
      par_in = '1;
      idle(SETTLE);
      ld_n = 1'b0;
      idle(SS);
      chk("R9", q_last, 1'b0);
      idle(1);
      chk("R9", q_last, 1'b1);
      ld_n = 1'b1;
      model = '1;
      idle(SETTLE);

      // R8 ordering of a loaded word then serial bits
      d = 12'hA5C;
      sbits = 12'h0B3;
      do_load(d, 1'b1);
      for (int i = 0; i < W + 4; i++) begin
         chk("R8", q_last, (i < W) ? d[W-1-i] : sbits[i-W]);
         pulse(i[0], sbits[i % W]);
      end

      // R3: parallel input changes with load high are ignored
      do_load(12'h801, 1'b0);
      par_in = 12'h7FE;
      idle(SETTLE);
      check_out("R3");
      for (int i = 0; i < W; i++) begin
         chk("R3", q_last, model[W-1]);
         pulse(1'b0, 1'b0);
      end

      // R5: inhibit on clk_b, then roles swapped
      do_load(12'hF0F, 1'b0);
      for (int k = 0; k < 2; k++) begin
         ser_in = 1'b1;
         idle(SETTLE);
         if (k == 0) clk_a = 1'b1; else clk_b = 1'b1;
         idle(SETTLE);
         model = shift_in(model, 1'b1);
         if (k == 0) clk_b = 1'b1; else clk_a = 1'b1;
         idle(SETTLE);
         if (k == 0) clk_a = 1'b0; else clk_b = 1'b0;
         idle(SETTLE);
         for (int j = 0; j < 3; j++) begin
            ser_in = ~ser_in;
            if (k == 0) clk_a = 1'b1; else clk_b = 1'b1;
            idle(SETTLE);
            if (k == 0) clk_a = 1'b0; else clk_b = 1'b0;
            idle(SETTLE);
            check_out("R5");
         end
         clk_a = 1'b0; clk_b = 1'b0;
         idle(SETTLE);
         check_out("R5");
         for (int i = 0; i < W; i++) pulse(k[0], 1'b0);
         for (int i = 0; i < W; i++) begin
            chk("R5", q_last, model[W-1]);
            pulse(1'b1, 1'b1);
         end
      end

      // random mix
      for (int n = 0; n < 300; n++) begin
         case ($urandom % 5)
            0: do_load(W'($urandom), 1'($urandom));
            1: pulse(1'b0, 1'($urandom));
            2: pulse(1'b1, 1'($urandom));
            3: begin
               par_in = W'($urandom);
               idle(SETTLE);
               check_out("R3");
            end
            default: begin
               ser_in = 1'($urandom);
               idle(SETTLE);
               check_out("R6");
            end
         endcase
      end

      // R1 reset in mid-operation
      do_load('1, 1'b0);
      rst_n = 1'b0;
      idle(2);
      chk("R1", q_last, 1'b0);
      chk("R1", q_last_n, 1'b1);
      rst_n = 1'b1;
      idle(SETTLE);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule